// File: doc/BRIEF.md
# Bounds-Checked Banked Address Generator

This block turns one addressing request per cycle into a 20-bit physical word address, or into a protection trap. It holds the delimiters of the current code segment and data area, three base registers for data (data base, frame pointer, stack top), a mode bit, and three 4-bit bank registers: one for code, one for the stack and one for an extra data segment. A request names its kind: instruction fetch, direct data, indirect data, or absolute. The block forms a 16-bit offset from the selected base, the displacement and an optional index value. It checks that offset against the segment limits when the processor runs in user mode. It then places the matching bank number above the offset.

In privileged mode every bound check is skipped and offsets wrap modulo 2^16. Absolute requests carry a full physical address that is passed through unchanged. All registers are loaded through a single write port, which the operating-system side of the processor drives. The result is registered, so every request gets exactly one response one cycle later.

Top module: `banked_addr_gen`

## Requirements
- R1: Each cycle with `req_valid` high yields `rsp_valid` high on the following cycle. `rsp_valid` is low one cycle after a cycle with `req_valid` low.
- R2: After reset the outputs are zero, every segment, base and bank register is zero, and the mode is privileged.
- R3: A write with `wr_en` high loads the register picked by `wr_sel`, and a request sees it from the next cycle on. A request in the same cycle sees the old value. Select codes: 0 code low limit, 1 code high limit, 2 data low limit, 3 data high limit, 4 data base, 5 frame pointer, 6 stack top, 7 code bank, 8 stack bank, 9 extra-data bank, 10 mode (bit 0: 1 = privileged, 0 = user). Banks take the low 4 bits of `wr_data`.
- R4: A fetch (`req_kind` = 0) uses `req_disp` as its offset and ignores the index. Its address is {code bank, offset}.
- R5: In user mode, a fetch whose offset is below the code low limit or above the code high limit traps with cause 1. The limits themselves are legal.
- R6: A direct data request (`req_kind` = 1) adds `req_disp` to the base chosen by `req_base` (0 data base, 1 frame pointer, 2 stack top, 3 data base). When `req_index_en` is set it also adds `req_index`. The sum is taken modulo 2^16.
- R7: An indirect data request (`req_kind` = 2) always uses the data base, whatever `req_base` holds. The index is applied as in R6.
- R8: Data-base-relative offsets take the extra-data bank. Frame- and stack-relative offsets take the stack bank.
- R9: In user mode, a data offset outside the inclusive data limits traps with cause 2. So does any sum that carries out of bit 15.
- R10: In privileged mode no fetch or data request traps, and a carried sum wraps.
- R11: An absolute request (`req_kind` = 3) returns `req_abs_addr` in privileged mode. In user mode it traps with cause 3.
- R12: A trapped response has `rsp_addr` zero and a nonzero cause. A response that did not trap has cause 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | 16 | Write data |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 direct, 2 indirect, 3 absolute |
| req_base | input | 2 | Base select for direct data requests |
| req_disp | input | 16 | Displacement, or program counter for a fetch |
| req_index_en | input | 1 | Add the index value |
| req_index | input | 16 | Index register value |
| req_abs_addr | input | 20 | Physical address for absolute requests |
| rsp_valid | output | 1 | Response present |
| rsp_trap | output | 1 | Request was refused |
| rsp_cause | output | 2 | 0 none, 1 code bounds, 2 data bounds, 3 privilege |
| rsp_addr | output | 20 | Physical word address |

## Verification
Every result of this block is due one clock edge after the request that caused it. A register write takes effect one edge after the write. The bench drives each request on a falling edge and reads the response on the next falling edge, which is the first moment after the capturing rising edge. It never samples at a rising edge. A write issued in the same cycle as a request is checked against the old register value. A follow-up request one cycle later is checked against the new value.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int OFF_W_DEF  = 16;
  localparam int BANK_W_DEF = 4;
  localparam int SEL_W      = 4;

  // segment/base register slots
  localparam int SEG_CODE_LO = 0;
  localparam int SEG_CODE_HI = 1;
  localparam int SEG_DATA_LO = 2;
  localparam int SEG_DATA_HI = 3;
  localparam int SEG_DBASE   = 4;
  localparam int SEG_FRAME   = 5;
  localparam int SEG_STKTOP  = 6;
  localparam int NSEG        = 7;

  // bank register slots
  localparam int BANK_CODE  = 0;
  localparam int BANK_STACK = 1;
  localparam int BANK_EXTRA = 2;
  localparam int NBANK      = 3;

  localparam int SEL_MODE   = NSEG + NBANK;

  typedef enum logic [1:0] {
    KIND_FETCH    = 2'd0,
    KIND_DIRECT   = 2'd1,
    KIND_INDIRECT = 2'd2,
    KIND_ABS      = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_CODE = 2'd1,
    CAUSE_DATA = 2'd2,
    CAUSE_PRIV = 2'd3
  } cause_e;
endpackage

// File: rtl/bag_regs.sv
module bag_regs
  import bag_pkg::*;
#(
  parameter int OFF_W  = OFF_W_DEF,
  parameter int BANK_W = BANK_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [OFF_W-1:0]             wr_data,
  output logic [NSEG-1:0][OFF_W-1:0]   seg_q,
  output logic [NBANK-1:0][BANK_W-1:0] bank_q,
  output logic                         priv_q
);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic             we;
    logic [OFF_W-1:0] d;
    assign we = wr_en && (wr_sel == SEL_W'(g));
    always_comb begin
      d = seg_q[g];
      if (we) d = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[g] <= '0;
      else        seg_q[g] <= d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              we;
    logic [BANK_W-1:0] d;
    assign we = wr_en && (wr_sel == SEL_W'(NSEG + b));
    always_comb begin
      d = bank_q[b];
      if (we) d = wr_data[BANK_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[b] <= '0;
      else        bank_q[b] <= d;
    end
  end

  logic mode_we;
  logic priv_d;
  assign mode_we = wr_en && (wr_sel == SEL_W'(SEL_MODE));
  always_comb begin
    priv_d = priv_q;
    if (mode_we) priv_d = wr_data[0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) priv_q <= 1'b1;
    else        priv_q <= priv_d;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (priv_q == $past(wr_data[0]))); // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(priv_q)); // R3

endmodule

// File: rtl/bag_offset.sv
module bag_offset
  import bag_pkg::*;
#(
  parameter int OFF_W  = OFF_W_DEF,
  parameter int BANK_W = BANK_W_DEF
) (
  input  logic [1:0]                   kind,
  input  logic [1:0]                   base_sel,
  input  logic [OFF_W-1:0]             disp,
  input  logic                         index_en,
  input  logic [OFF_W-1:0]             index,
  input  logic [NSEG-1:0][OFF_W-1:0]   seg_q,
  input  logic [NBANK-1:0][BANK_W-1:0] bank_q,
  output logic [OFF_W-1:0]             off,
  output logic                         carry,
  output logic [BANK_W-1:0]            bank,
  output logic [OFF_W-1:0]             lim_lo,
  output logic [OFF_W-1:0]             lim_hi
);
  localparam int SUM_W = OFF_W + 2;

  logic [OFF_W-1:0] base;
  logic [OFF_W-1:0] idx_term;
  logic [SUM_W-1:0] sum;
  logic             stack_rel;

  always_comb begin
    base      = '0;
    stack_rel = 1'b0;
    idx_term  = index_en ? index : '0;
    bank      = bank_q[BANK_EXTRA];
    lim_lo    = seg_q[SEG_DATA_LO];
    lim_hi    = seg_q[SEG_DATA_HI];
    unique case (kind_e'(kind))
      KIND_FETCH: begin
        idx_term = '0;
        bank     = bank_q[BANK_CODE];
        lim_lo   = seg_q[SEG_CODE_LO];
        lim_hi   = seg_q[SEG_CODE_HI];
      end
      KIND_DIRECT: begin
        unique case (base_sel)
          2'd1:    begin base = seg_q[SEG_FRAME];  stack_rel = 1'b1; end
          2'd2:    begin base = seg_q[SEG_STKTOP]; stack_rel = 1'b1; end
          default: base = seg_q[SEG_DBASE];
        endcase
        if (stack_rel) bank = bank_q[BANK_STACK];
      end
      KIND_INDIRECT: base = seg_q[SEG_DBASE];
      default: idx_term = '0;
    endcase
  end

  assign sum   = SUM_W'(base) + SUM_W'(disp) + SUM_W'(idx_term);
  assign off   = sum[OFF_W-1:0];
  assign carry = |sum[SUM_W-1:OFF_W];

endmodule

// File: rtl/bag_check.sv
module bag_check
  import bag_pkg::*;
#(
  parameter int OFF_W = OFF_W_DEF
) (
  input  logic [1:0]       kind,
  input  logic             priv,
  input  logic [OFF_W-1:0] off,
  input  logic             carry,
  input  logic [OFF_W-1:0] lim_lo,
  input  logic [OFF_W-1:0] lim_hi,
  output logic             trap,
  output logic [1:0]       cause
);
  logic outside;
  assign outside = (off < lim_lo) || (off > lim_hi);

  always_comb begin
    cause = CAUSE_NONE;
    if (!priv) begin
      unique case (kind_e'(kind))
        KIND_FETCH:    if (outside) cause = CAUSE_CODE;
        KIND_ABS:      cause = CAUSE_PRIV;
        default:       if (outside || carry) cause = CAUSE_DATA;
      endcase
    end
  end
  assign trap = (cause != CAUSE_NONE);

endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
  import bag_pkg::*;
#(
  parameter int OFF_W  = OFF_W_DEF,
  parameter int BANK_W = BANK_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [OFF_W-1:0]        wr_data,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [1:0]              req_base,
  input  logic [OFF_W-1:0]        req_disp,
  input  logic                    req_index_en,
  input  logic [OFF_W-1:0]        req_index,
  input  logic [OFF_W+BANK_W-1:0] req_abs_addr,
  output logic                    rsp_valid,
  output logic                    rsp_trap,
  output logic [1:0]              rsp_cause,
  output logic [OFF_W+BANK_W-1:0] rsp_addr
);
  localparam int ADDR_W = OFF_W + BANK_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [NSEG-1:0][OFF_W-1:0]   seg_q;
  logic [NBANK-1:0][BANK_W-1:0] bank_q;
  logic                         priv_q;
  logic [OFF_W-1:0]             off, lim_lo, lim_hi;
  logic                         carry, trap;
  logic [BANK_W-1:0]            bank;
  logic [1:0]                   cause;

  bag_regs #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seg_q(seg_q), .bank_q(bank_q), .priv_q(priv_q)
  );

  bag_offset #(.OFF_W(OFF_W), .BANK_W(BANK_W)) u_off (
    .kind(req_kind), .base_sel(req_base), .disp(req_disp),
    .index_en(req_index_en), .index(req_index), .seg_q(seg_q),
    .bank_q(bank_q), .off(off), .carry(carry), .bank(bank),
    .lim_lo(lim_lo), .lim_hi(lim_hi)
  );

  bag_check #(.OFF_W(OFF_W)) u_chk (
    .kind(req_kind), .priv(priv_q), .off(off), .carry(carry),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .trap(trap), .cause(cause)
  );

  logic              valid_d, trap_d;
  logic [1:0]        cause_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    valid_d = req_valid;
    trap_d  = req_valid && trap;
    cause_d = req_valid ? cause : CAUSE_NONE;
    addr_d  = '0;
    if (req_valid && !trap) begin
      if (kind_e'(req_kind) == KIND_ABS) addr_d = req_abs_addr;
      else                               addr_d = {bank, off};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_trap  <= trap_d;
      rsp_cause <= cause_d;
      rsp_addr  <= addr_d;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !rsp_valid); // R1
  AST_TRAP_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_trap |-> (rsp_valid && rsp_addr == '0 && rsp_cause != CAUSE_NONE)); // R12
  AST_CAUSE_CLEAN: assert property (@(posedge clk) disable iff (!rst_ni)
    !rsp_trap |-> (rsp_cause == CAUSE_NONE)); // R12
  AST_PRIV_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && priv_q) |=> !rsp_trap); // R10
  AST_FETCH_BANK: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && kind_e'(req_kind) == KIND_FETCH) |=>
      (rsp_trap || rsp_addr[ADDR_W-1:OFF_W] == $past(bank_q[BANK_CODE]))); // R4
  AST_USER_ABS_TRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !priv_q && kind_e'(req_kind) == KIND_ABS) |=>
      (rsp_trap && rsp_cause == CAUSE_PRIV)); // R11

endmodule

// File: tb/sim_banked_addr_gen.sv
module sim_banked_addr_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_kind, req_base;
  logic [15:0] req_disp, req_index;
  logic        req_index_en;
  logic [19:0] req_abs_addr;
  logic        rsp_valid, rsp_trap;
  logic [1:0]  rsp_cause;
  logic [19:0] rsp_addr;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  banked_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_base(req_base), .req_disp(req_disp), .req_index_en(req_index_en),
    .req_index(req_index), .req_abs_addr(req_abs_addr),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
    .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [1:0] k, input logic [1:0] b, input logic [15:0] disp,
                       input logic ie, input logic [15:0] ix, input logic [19:0] abs_a);
    req_valid = 1'b1; req_kind = k; req_base = b; req_disp = disp;
    req_index_en = ie; req_index = ix; req_abs_addr = abs_a;
  endtask

  task automatic expect_rsp(input string tag, input logic trap, input logic [1:0] cause,
                            input logic [19:0] addr);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " trap"},  32'(rsp_trap),  32'(trap));
    chk({tag, " cause"}, 32'(rsp_cause), 32'(cause));
    chk({tag, " addr"},  32'(rsp_addr),  32'(addr));
  endtask

  task automatic req(input string tag, input logic [1:0] k, input logic [1:0] b,
                     input logic [15:0] disp, input logic ie, input logic [15:0] ix,
                     input logic [19:0] abs_a, input logic trap, input logic [1:0] cause,
                     input logic [19:0] addr);
    @(negedge clk);
    drive(k, b, disp, ie, ix, abs_a);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, trap, cause, addr);
  endtask

  task automatic t_reset();
    chk("R2 reset valid", 32'(rsp_valid), 0);
    chk("R2 reset trap",  32'(rsp_trap), 0);
    chk("R2 reset addr",  32'(rsp_addr), 0);
    // privileged at reset, all limits and banks zero
    req("R2 priv fetch", 2'd0, 2'd0, 16'h1234, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'h01234);
    req("R2 zero base", 2'd1, 2'd2, 16'h0042, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'h00042);
  endtask

  task automatic t_setup();
    wr(4'd0, 16'h1000); wr(4'd1, 16'h1FFF);
    wr(4'd2, 16'h4000); wr(4'd3, 16'h7FFF);
    wr(4'd4, 16'h5000); wr(4'd5, 16'h6000); wr(4'd6, 16'h6800);
    wr(4'd7, 16'h0003); wr(4'd8, 16'h0005); wr(4'd9, 16'hFFFA);
    wr(4'd10, 16'h0000);
  endtask

  task automatic t_fetch();
    req("R4 fetch lo edge", 2'd0, 2'd0, 16'h1000, 1'b1, 16'h0100, 20'h0, 1'b0, 2'd0, 20'h31000);
    req("R5 fetch hi edge", 2'd0, 2'd0, 16'h1FFF, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'h31FFF);
    req("R5 fetch below",   2'd0, 2'd0, 16'h0FFF, 1'b0, 16'h0, 20'h0, 1'b1, 2'd1, 20'h0);
    req("R5 fetch above",   2'd0, 2'd0, 16'h2000, 1'b0, 16'h0, 20'h0, 1'b1, 2'd1, 20'h0);
  endtask

  task automatic t_direct();
    req("R6 R8 dbase",  2'd1, 2'd0, 16'h0010, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA5010);
    req("R6 R8 frame idx", 2'd1, 2'd1, 16'h0004, 1'b1, 16'h0100, 20'h0, 1'b0, 2'd0, 20'h56104);
    req("R6 R8 stack noidx", 2'd1, 2'd2, 16'h0020, 1'b0, 16'h0055, 20'h0, 1'b0, 2'd0, 20'h56820);
    req("R6 base3 dbase", 2'd1, 2'd3, 16'h0001, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA5001);
  endtask

  task automatic t_indirect();
    req("R7 indirect", 2'd2, 2'd2, 16'h0030, 1'b1, 16'h0002, 20'h0, 1'b0, 2'd0, 20'hA5032);
  endtask

  task automatic t_data_bounds();
    req("R9 hi edge", 2'd1, 2'd0, 16'h2FFF, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA7FFF);
    req("R9 above",   2'd1, 2'd0, 16'h3000, 1'b0, 16'h0, 20'h0, 1'b1, 2'd2, 20'h0);
    req("R9 carry",   2'd1, 2'd0, 16'hF000, 1'b0, 16'h0, 20'h0, 1'b1, 2'd2, 20'h0);
    req("R9 idx carry", 2'd2, 2'd0, 16'h1000, 1'b1, 16'hF000, 20'h0, 1'b1, 2'd2, 20'h0);
    wr(4'd4, 16'h3FFF);
    req("R9 below",   2'd1, 2'd0, 16'h0000, 1'b0, 16'h0, 20'h0, 1'b1, 2'd2, 20'h0);
    req("R9 lo edge", 2'd1, 2'd0, 16'h0001, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA4000);
    wr(4'd4, 16'h5000);
  endtask

  task automatic t_abs_user();
    req("R11 user abs", 2'd3, 2'd0, 16'h0, 1'b0, 16'h0, 20'hFEDCB, 1'b1, 2'd3, 20'h0);
  endtask

  task automatic t_priv();
    wr(4'd10, 16'h0001);
    req("R10 wrap",    2'd1, 2'd0, 16'hF000, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA4000);
    req("R10 fetch out", 2'd0, 2'd0, 16'h0FFF, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'h30FFF);
    req("R10 data out", 2'd1, 2'd0, 16'h3000, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'hA8000);
    req("R11 priv abs", 2'd3, 2'd1, 16'h1111, 1'b1, 16'h2222, 20'hFEDCB, 1'b0, 2'd0, 20'hFEDCB);
    wr(4'd10, 16'h0000);
  endtask

  task automatic t_write_timing();
    // write and request in the same cycle: request sees the old code bank
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd7; wr_data = 16'h0007;
    drive(2'd0, 2'd0, 16'h1000, 1'b0, 16'h0, 20'h0);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R3 old bank", 1'b0, 2'd0, 20'h31000);
    req("R3 new bank", 2'd0, 2'd0, 16'h1000, 1'b0, 16'h0, 20'h0, 1'b0, 2'd0, 20'h71000);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    drive(2'd0, 2'd0, 16'h1800, 1'b0, 16'h0, 20'h0);
    @(negedge clk);
    expect_rsp("R1 first", 1'b0, 2'd0, 20'h71800);
    drive(2'd0, 2'd0, 16'h3000, 1'b0, 16'h0, 20'h0);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R1 second", 1'b1, 2'd1, 20'h0);
    @(negedge clk);
    chk("R1 idle", 32'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_kind = '0; req_base = '0; req_disp = '0;
    req_index_en = 1'b0; req_index = '0; req_abs_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_setup();
    t_fetch();
    t_direct();
    t_indirect();
    t_data_bounds();
    t_abs_user();
    t_priv();
    t_write_timing();
    t_pipeline();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule